// File: doc/BRIEF.md
# Invocation Relay Proxy with Endpoint Relocation

This block sits on the client side of a method call and acts as the client's stand-in for one remote server object. It takes one call at a time from the client (a method code plus an argument) and drives it onto a simple request/acknowledge bus. The call goes to the address the proxy last knew for the server, and the server's return value goes back to the client. The proxy holds two references, fixed when the block is built: the server's last known address and the address of a locator service.

When the server does not acknowledge within a bounded window, the proxy withdraws the request and asks the locator where the object now lives, passing the object's identifier. It stores the returned address and then replays the original call there. Every later call goes straight to the new address. Each call gets at most one relocation. If the replay also goes unanswered, the client receives a timeout error. If the locator says the object is not registered, the proxy raises an exception line towards the scheduler. It then answers every further call with an error and puts nothing more on the bus.

Top module: `invoke_relay`

## Requirements
- R1: After reset, `cli_ready` is 1 and `bus_req`, `bus_cancel`, `loc_req`, `cli_rsp_valid` and `sched_exc` are 0. The first call is sent to the parameter `SRV_ADDR_INIT`.
- R2: A call accepted while `cli_ready` is 1 appears on the bus in the next cycle, with `bus_addr` set to the stored server address and `bus_meth`/`bus_arg` equal to the accepted values. `cli_ready` is 0 from that cycle until the call's response is issued.
- R3: When `bus_ack` is high during a request, the cycle after it carries a one-cycle `cli_rsp_valid` with `cli_rsp_code` = 0 (success) and `cli_rsp_data` equal to the `bus_rdata` that came with the acknowledge.
- R4: A request lasts at most `TO_CYC` (16) cycles. An acknowledge in the 16th cycle still completes the call. Without one, in the 17th cycle `bus_req` is 0 and `bus_cancel` is high for exactly one cycle.
- R5: After the first timeout of a call, `loc_req` goes high in the cancel cycle with `loc_oid` = `OBJ_ID` and `loc_addr` = `LOC_ADDR`. It stays high until `loc_ack`.
- R6: On a lookup without error, the proxy stores `loc_raddr`. It replays the same method and argument to that address, and the replay appears on the bus `UPD_CYC`+1 cycles (7 by default, always between 5 and 8) after the cycle in which `loc_ack` was high.
- R7: Calls issued after a relocation go directly to the relocated address with no lookup.
- R8: If a replayed request also times out, the response in the cancel cycle has code 1 (timeout) and data 0. No second lookup is made.
- R9: If `loc_ack` arrives with `loc_err` = 1, the next cycle gives a response with code 2 (unknown object), and `sched_exc` rises and stays high until reset.
- R10: Once `sched_exc` is high, each call is accepted and answered in the following cycle with code 2, and `bus_req` and `loc_req` stay 0.
- R11: A client call presented while `cli_ready` is 0, including during a relocation, is not captured. The replay keeps the original method and argument, and the held call is taken only once `cli_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cli_valid | input | 1 | Client presents a call |
| cli_ready | output | 1 | Proxy can take a call |
| cli_meth | input | METH_W | Method code of the call |
| cli_arg | input | DATA_W | Argument of the call |
| cli_rsp_valid | output | 1 | One-cycle response strobe |
| cli_rsp_code | output | 2 | 0 success, 1 timeout, 2 unknown object |
| cli_rsp_data | output | DATA_W | Return value (0 on error) |
| bus_req | output | 1 | Request to the server, held until acknowledge or timeout |
| bus_addr | output | ADDR_W | Target server address |
| bus_meth | output | METH_W | Method code on the bus |
| bus_arg | output | DATA_W | Argument on the bus |
| bus_cancel | output | 1 | One-cycle withdraw pulse after a timeout |
| bus_ack | input | 1 | Server acknowledge |
| bus_rdata | input | DATA_W | Server return value, valid with `bus_ack` |
| loc_req | output | 1 | Lookup request to the locator |
| loc_addr | output | ADDR_W | Locator reference address |
| loc_oid | output | OID_W | Object identifier to look up |
| loc_ack | input | 1 | Locator answer strobe |
| loc_err | input | 1 | Locator reports unknown object |
| loc_raddr | input | ADDR_W | Current server address from the locator |
| sched_exc | output | 1 | Sticky exception to the scheduler |

## Verification
The hardest state to reach from the ports is a replay that times out a second time. Getting there takes a full 16-cycle silent request, a successful lookup and a second silent request in a row, while the client keeps a competing call asserted. Each bench scenario plays server and locator in sequence from a task. The task withholds the acknowledge for the whole window, answers the lookup with a fresh address, and counts negative edges from the locator's answer to the replay's first cycle. The acknowledge in the very last cycle of the window is driven separately so that the boundary between completion and cancel is seen.

// File: rtl/relay_pkg.sv
package relay_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALL,
        ST_LOOKUP,
        ST_SETTLE,
        ST_DEAD
    } relay_state_e;

    typedef enum logic [1:0] {
        RSP_OK      = 2'd0,
        RSP_TIMEOUT = 2'd1,
        RSP_UNKNOWN = 2'd2
    } rsp_code_e;

    // width of a counter that must reach lim-1
    function automatic int unsigned ctr_width(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim);
    endfunction

endpackage

// File: rtl/relay_watchdog.sv
module relay_watchdog
    import relay_pkg::*;
#(
    parameter int unsigned TO_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ack,
    output logic expire
);
    localparam int unsigned CW = ctr_width(TO_CYC);
    localparam logic [CW-1:0] LAST = CW'(TO_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || ack) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && !ack && (cnt == LAST);

    // the controller must drop the request once the window is spent
    p_run_stops_r4: assert property (@(posedge clk) disable iff (rst)
        expire |=> !run);

endmodule

// File: rtl/relay_endpoint.sv
module relay_endpoint
    import relay_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] INIT_ADDR = '0,
    parameter int unsigned UPD_CYC = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] new_addr,
    output logic [ADDR_W-1:0] addr,
    output logic              settled
);
    localparam int unsigned CW = ctr_width(UPD_CYC);
    localparam logic [CW-1:0] LAST = CW'(UPD_CYC - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [CW-1:0]     cnt;
    logic              busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= INIT_ADDR;
            busy   <= 1'b0;
            cnt    <= '0;
        end else if (load) begin
            addr_q <= new_addr;
            busy   <= 1'b1;
            cnt    <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign addr    = addr_q;
    assign settled = busy && (cnt == LAST);

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(addr));

    p_settle_once_r6: assert property (@(posedge clk) disable iff (rst)
        settled && !load |=> !settled);

endmodule

// File: rtl/invoke_relay.sv
module invoke_relay
    import relay_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned METH_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned OID_W   = 8,
    parameter int unsigned TO_CYC  = 16,
    parameter int unsigned UPD_CYC = 6,
    parameter logic [ADDR_W-1:0] SRV_ADDR_INIT = ADDR_W'(16'h0100),
    parameter logic [ADDR_W-1:0] LOC_ADDR      = ADDR_W'(16'h00F0),
    parameter logic [OID_W-1:0]  OBJ_ID        = OID_W'(8'h2A)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cli_valid,
    output logic              cli_ready,
    input  logic [METH_W-1:0] cli_meth,
    input  logic [DATA_W-1:0] cli_arg,
    output logic              cli_rsp_valid,
    output logic [1:0]        cli_rsp_code,
    output logic [DATA_W-1:0] cli_rsp_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [METH_W-1:0] bus_meth,
    output logic [DATA_W-1:0] bus_arg,
    output logic              bus_cancel,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              loc_req,
    output logic [ADDR_W-1:0] loc_addr,
    output logic [OID_W-1:0]  loc_oid,
    input  logic              loc_ack,
    input  logic              loc_err,
    input  logic [ADDR_W-1:0] loc_raddr,
    output logic              sched_exc
);
    typedef struct packed {
        logic [METH_W-1:0] meth;
        logic [DATA_W-1:0] arg;
    } call_t;

    relay_state_e      state;
    call_t             call_q;
    logic              replay_q;
    logic              rsp_valid_q;
    rsp_code_e         rsp_code_q;
    logic [DATA_W-1:0] rsp_data_q;
    logic              cancel_q;
    logic              exc_q;

    logic              expire;
    logic              ep_load;
    logic              ep_settled;
    logic [ADDR_W-1:0] ep_addr;

    relay_watchdog #(.TO_CYC(TO_CYC)) u_wdog (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_CALL),
        .ack    (bus_ack),
        .expire (expire)
    );

    assign ep_load = (state == ST_LOOKUP) && loc_ack && !loc_err;

    relay_endpoint #(
        .ADDR_W    (ADDR_W),
        .INIT_ADDR (SRV_ADDR_INIT),
        .UPD_CYC   (UPD_CYC)
    ) u_ep (
        .clk      (clk),
        .rst      (rst),
        .load     (ep_load),
        .new_addr (loc_raddr),
        .addr     (ep_addr),
        .settled  (ep_settled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            call_q      <= '0;
            replay_q    <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_code_q  <= RSP_OK;
            rsp_data_q  <= '0;
            cancel_q    <= 1'b0;
            exc_q       <= 1'b0;
        end else begin
            rsp_valid_q <= 1'b0;
            cancel_q    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cli_valid) begin
                        call_q   <= '{meth: cli_meth, arg: cli_arg};
                        replay_q <= 1'b0;
                        state    <= ST_CALL;
                    end
                end
                ST_CALL: begin
                    if (bus_ack) begin
                        rsp_valid_q <= 1'b1;
                        rsp_code_q  <= RSP_OK;
                        rsp_data_q  <= bus_rdata;
                        state       <= ST_IDLE;
                    end else if (expire) begin
                        cancel_q <= 1'b1;
                        if (replay_q) begin
                            rsp_valid_q <= 1'b1;
                            rsp_code_q  <= RSP_TIMEOUT;
                            rsp_data_q  <= '0;
                            state       <= ST_IDLE;
                        end else begin
                            state <= ST_LOOKUP;
                        end
                    end
                end
                ST_LOOKUP: begin
                    if (loc_ack) begin
                        if (loc_err) begin
                            rsp_valid_q <= 1'b1;
                            rsp_code_q  <= RSP_UNKNOWN;
                            rsp_data_q  <= '0;
                            exc_q       <= 1'b1;
                            state       <= ST_DEAD;
                        end else begin
                            state <= ST_SETTLE;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (ep_settled) begin
                        replay_q <= 1'b1;
                        state    <= ST_CALL;
                    end
                end
                ST_DEAD: begin
                    if (cli_valid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_code_q  <= RSP_UNKNOWN;
                        rsp_data_q  <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cli_ready     = (state == ST_IDLE) || (state == ST_DEAD);
    assign cli_rsp_valid = rsp_valid_q;
    assign cli_rsp_code  = rsp_code_q;
    assign cli_rsp_data  = rsp_data_q;
    assign bus_req       = (state == ST_CALL);
    assign bus_addr      = ep_addr;
    assign bus_meth      = call_q.meth;
    assign bus_arg       = call_q.arg;
    assign bus_cancel    = cancel_q;
    assign loc_req       = (state == ST_LOOKUP);
    assign loc_addr      = LOC_ADDR;
    assign loc_oid       = OBJ_ID;
    assign sched_exc     = exc_q;

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req || bus_cancel);

    p_ack_answers_r3: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_ack |=> cli_rsp_valid && (cli_rsp_code == 2'd0));

    p_cancel_after_req_r4: assert property (@(posedge clk) disable iff (rst)
        bus_cancel |-> $past(bus_req) && !bus_req);

    p_loc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        loc_req && !loc_ack |=> loc_req);

    p_exc_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        sched_exc |=> sched_exc);

    p_dead_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        sched_exc |-> !bus_req && !loc_req);

    p_busy_client_r11: assert property (@(posedge clk) disable iff (rst)
        cli_valid && cli_ready && !sched_exc |=> !cli_ready);

endmodule

// File: tb/tb_invoke_relay.sv
module tb_invoke_relay;
    localparam logic [15:0] A_INIT = 16'h0100;
    localparam logic [15:0] A_LOC  = 16'h00F0;
    localparam logic [7:0]  OID    = 8'h2A;
    localparam logic [15:0] A_NEW1 = 16'h0340;
    localparam logic [15:0] A_NEW2 = 16'h0580;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cli_valid = 1'b0;
    logic        cli_ready;
    logic [3:0]  cli_meth = '0;
    logic [31:0] cli_arg = '0;
    logic        cli_rsp_valid;
    logic [1:0]  cli_rsp_code;
    logic [31:0] cli_rsp_data;
    logic        bus_req;
    logic [15:0] bus_addr;
    logic [3:0]  bus_meth;
    logic [31:0] bus_arg;
    logic        bus_cancel;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        loc_req;
    logic [15:0] loc_addr;
    logic [7:0]  loc_oid;
    logic        loc_ack = 1'b0;
    logic        loc_err = 1'b0;
    logic [15:0] loc_raddr = '0;
    logic        sched_exc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    invoke_relay dut (
        .clk(clk), .rst(rst),
        .cli_valid(cli_valid), .cli_ready(cli_ready),
        .cli_meth(cli_meth), .cli_arg(cli_arg),
        .cli_rsp_valid(cli_rsp_valid), .cli_rsp_code(cli_rsp_code),
        .cli_rsp_data(cli_rsp_data),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_meth(bus_meth),
        .bus_arg(bus_arg), .bus_cancel(bus_cancel),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .loc_req(loc_req), .loc_addr(loc_addr), .loc_oid(loc_oid),
        .loc_ack(loc_ack), .loc_err(loc_err), .loc_raddr(loc_raddr),
        .sched_exc(sched_exc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // present one call; returns at the negedge where bus_req should be up
    task automatic issue(input logic [3:0] m, input logic [31:0] a, input bit hold);
        chk("R2 ready before call", 32'(cli_ready), 32'd1);
        cli_valid = 1'b1; cli_meth = m; cli_arg = a;
        tick();
        if (!hold) cli_valid = 1'b0;
        chk("R2 bus_req", 32'(bus_req), 32'd1);
        chk("R2 ready low", 32'(cli_ready), 32'd0);
    endtask

    // acknowledge in cycle lat of the request and check the response
    task automatic serve(input int lat, input logic [31:0] data, input string tag);
        for (int n = 1; n < lat; n++) tick();
        bus_ack = 1'b1; bus_rdata = data;
        tick();
        bus_ack = 1'b0; bus_rdata = '0;
        chk({tag, " rsp_valid"}, 32'(cli_rsp_valid), 32'd1);
        chk({tag, " rsp_code"}, 32'(cli_rsp_code), 32'd0);
        chk({tag, " rsp_data"}, cli_rsp_data, data);
        chk({tag, " no cancel"}, 32'(bus_cancel), 32'd0);
        chk({tag, " bus idle"}, 32'(bus_req), 32'd0);
    endtask

    // let the request run silent; returns in the cycle after the window
    task automatic run_out(input string tag);
        int high = 0;
        for (int n = 1; n <= 16; n++) begin
            if (bus_req) high++;
            tick();
        end
        chk({tag, " req cycles"}, 32'(high), 32'd16);
        chk({tag, " req dropped"}, 32'(bus_req), 32'd0);
        chk({tag, " cancel"}, 32'(bus_cancel), 32'd1);
    endtask

    // answer the locator now; returns cycles until the replay shows
    task automatic answer_loc(input logic [15:0] a, output int gap);
        loc_ack = 1'b1; loc_raddr = a; loc_err = 1'b0;
        gap = 0;
        do begin
            tick();
            gap++;
            loc_ack = 1'b0;
            chk("R11 ready low while relocating", 32'(cli_ready), 32'd0);
        end while (!bus_req && gap < 20);
    endtask

    task automatic t_reset();
        chk("R1 ready", 32'(cli_ready), 32'd1);
        chk("R1 bus_req", 32'(bus_req), 32'd0);
        chk("R1 cancel", 32'(bus_cancel), 32'd0);
        chk("R1 loc_req", 32'(loc_req), 32'd0);
        chk("R1 rsp_valid", 32'(cli_rsp_valid), 32'd0);
        chk("R1 sched_exc", 32'(sched_exc), 32'd0);
    endtask

    task automatic t_plain_call();
        issue(4'h3, 32'h1111_0001, 1'b0);
        chk("R1 first address", 32'(bus_addr), 32'(A_INIT));
        chk("R2 method", 32'(bus_meth), 32'h3);
        chk("R2 arg", bus_arg, 32'h1111_0001);
        serve(3, 32'hCAFE_0003, "R3");
        chk("R3 ready back", 32'(cli_ready), 32'd1);
        tick();
        chk("R3 rsp one cycle", 32'(cli_rsp_valid), 32'd0);
    endtask

    task automatic t_last_cycle_ack();
        issue(4'h5, 32'h2222_0002, 1'b0);
        serve(16, 32'hBEEF_0016, "R4 ack in cycle 16");
        chk("R4 no lookup", 32'(loc_req), 32'd0);
        tick();
    endtask

    task automatic t_relocate();
        int gap;
        issue(4'h7, 32'h3333_0007, 1'b1);
        cli_meth = 4'h9; cli_arg = 32'h9999_0009;   // held competing call
        run_out("R4");
        chk("R5 loc_req", 32'(loc_req), 32'd1);
        chk("R5 oid", 32'(loc_oid), 32'(OID));
        chk("R5 loc_addr", 32'(loc_addr), 32'(A_LOC));
        tick(); tick();
        chk("R5 loc_req held", 32'(loc_req), 32'd1);
        answer_loc(A_NEW1, gap);
        chk("R6 settle gap", 32'(gap), 32'd7);
        chk("R6 gap in range", 32'((gap >= 5) && (gap <= 8)), 32'd1);
        chk("R6 replay addr", 32'(bus_addr), 32'(A_NEW1));
        chk("R11 replay method", 32'(bus_meth), 32'h7);
        chk("R11 replay arg", bus_arg, 32'h3333_0007);
        serve(2, 32'hD00D_0007, "R6 replay");
        // held call is taken at this edge
        tick();
        cli_valid = 1'b0;
        chk("R11 held taken", 32'(bus_req), 32'd1);
        chk("R11 held method", 32'(bus_meth), 32'h9);
        chk("R7 new addr direct", 32'(bus_addr), 32'(A_NEW1));
        serve(1, 32'h0000_0909, "R7");
        chk("R7 no lookup", 32'(loc_req), 32'd0);
        tick();
    endtask

    task automatic t_replay_timeout();
        int gap;
        issue(4'hA, 32'h4444_000A, 1'b0);
        chk("R7 call uses stored addr", 32'(bus_addr), 32'(A_NEW1));
        run_out("R8 first");
        chk("R8 lookup", 32'(loc_req), 32'd1);
        answer_loc(A_NEW2, gap);
        chk("R6 settle gap again", 32'(gap), 32'd7);
        chk("R8 replay addr", 32'(bus_addr), 32'(A_NEW2));
        run_out("R8 replay");
        chk("R8 rsp_valid", 32'(cli_rsp_valid), 32'd1);
        chk("R8 rsp_code", 32'(cli_rsp_code), 32'd1);
        chk("R8 rsp_data", cli_rsp_data, 32'd0);
        chk("R8 no second lookup", 32'(loc_req), 32'd0);
        tick();
        chk("R8 still no lookup", 32'(loc_req), 32'd0);
        chk("R8 ready", 32'(cli_ready), 32'd1);
    endtask

    task automatic t_unknown();
        issue(4'hC, 32'h5555_000C, 1'b0);
        chk("R7 addr", 32'(bus_addr), 32'(A_NEW2));
        run_out("R9");
        loc_ack = 1'b1; loc_err = 1'b1;
        tick();
        loc_ack = 1'b0; loc_err = 1'b0;
        chk("R9 rsp_valid", 32'(cli_rsp_valid), 32'd1);
        chk("R9 rsp_code", 32'(cli_rsp_code), 32'd2);
        chk("R9 sched_exc", 32'(sched_exc), 32'd1);
        chk("R9 no replay", 32'(bus_req), 32'd0);
        cli_valid = 1'b1; cli_meth = 4'h1; cli_arg = 32'h1;
        for (int k = 0; k < 2; k++) begin
            chk("R10 ready", 32'(cli_ready), 32'd1);
            tick();
            chk("R10 rsp_valid", 32'(cli_rsp_valid), 32'd1);
            chk("R10 rsp_code", 32'(cli_rsp_code), 32'd2);
            chk("R10 bus quiet", 32'(bus_req), 32'd0);
            chk("R10 locator quiet", 32'(loc_req), 32'd0);
        end
        cli_valid = 1'b0;
        for (int k = 0; k < 4; k++) tick();
        chk("R9 exc sticky", 32'(sched_exc), 32'd1);
        chk("R10 bus still quiet", 32'(bus_req), 32'd0);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_plain_call();
        t_last_cycle_ack();
        t_relocate();
        t_replay_timeout();
        t_unknown();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule